// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block arbitrates among 48 maskable peripheral interrupt lines and one non-maskable line on behalf of a CPU. Software gives each maskable line a 5-bit priority level through a small register port. Every cycle the block picks the most urgent pending line. It then presents the chosen level, a 6-bit vector number and a request flag to the CPU.

A smaller level value is more urgent. Level 31 parks a line so that it never wins. When two lines share a level, the lower-numbered line wins. The CPU drives its current mask level, and a maskable winner is forwarded only if its level is strictly below that mask. The non-maskable line ignores the mask, overrides every maskable line and reports a fixed level and vector. All CPU-facing outputs come from registers.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, every level register reads back 31, `irq_req` is 0, `irq_level` is 31 and `irq_vec` is 0.
- R2: A write with `wr_en` high to address `wr_addr` in the range 0..47 stores `wr_data` in that line's level register. Setting `rd_addr` returns that register on `rd_data` one clock later.
- R3: A line whose level is 31 never wins, even while its request is high.
- R4: Among pending lines, the one with the numerically smallest level wins.
- R5: When pending lines share the smallest level, the lowest-numbered line wins.
- R6: A maskable winner raises `irq_req` only when its level is strictly less than `cpu_mask`. If its level is equal to or above the mask, nothing is forwarded.
- R7: When nothing is forwarded, `irq_req` is 0, `irq_level` is 31 and `irq_vec` is 0.
- R8: While `nmi_req` is high, the outputs are `irq_req`=1, `irq_level`=15 and `irq_vec`=15. This holds for any mask value and any maskable requests.
- R9: A forwarded maskable line n reports `irq_vec` = 16 + n and its own level on `irq_level`.
- R10: The outputs reflect the inputs as sampled at the previous rising clock edge. A change takes effect one clock later and not before.
- R11: Writes to addresses 48..63 change no level register. Reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 48 | Maskable request lines, bit n = line n |
| nmi_req | input | 1 | Non-maskable request |
| cpu_mask | input | 5 | CPU's current interrupt mask level |
| wr_en | input | 1 | Level register write strobe |
| wr_addr | input | 6 | Line number to write |
| wr_data | input | 5 | Level value to write |
| rd_addr | input | 6 | Line number to read |
| rd_data | output | 5 | Registered read data |
| irq_req | output | 1 | Request to the CPU |
| irq_level | output | 5 | Level of the forwarded request |
| irq_vec | output | 6 | Vector number of the forwarded request |

## Verification
A change on `src_req`, `nmi_req` or `cpu_mask` must appear on the outputs exactly one rising edge later. A level write needs two edges: one to store the value and one to register the new arbitration result. A read shows up on `rd_data` one edge after `rd_addr` is set. The bench drives inputs on the falling edge and samples results on the following falling edge, so each check lands in the cycle where the result is due. The timing scenario also samples just after the drive point, before the rising edge, to show that the outputs have not yet moved.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int LVL_W = 5;
  localparam int IDX_W = 6;
  localparam logic [LVL_W-1:0] LVL_OFF = '1;

  typedef struct packed {
    logic             vld;
    logic [LVL_W-1:0] lvl;
    logic [IDX_W-1:0] idx;
  } cand_t;

  // Right candidate wins only when strictly more urgent: ties keep the left (lower index).
  function automatic cand_t pick_cand(cand_t a, cand_t b);
    if (b.vld && (!a.vld || b.lvl < a.lvl)) return b;
    return a;
  endfunction
endpackage

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
  import irq_lvl_pkg::*;
#(
  parameter int NUM_SRC = 48,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LVL_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LVL_W-1:0]  rd_data,
  output logic [LVL_W-1:0]  lvl_o [NUM_SRC]
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_o[i] <= LVL_OFF;
      end else if (wr_en && wr_addr == ADDR_W'(i)) begin
        lvl_o[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (int'(rd_addr) < NUM_SRC) begin
      rd_data <= lvl_o[rd_addr];
    end else begin
      rd_data <= '0;
    end
  end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irq_lvl_pkg::*;
#(
  parameter int NUM_SRC = 48
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [LVL_W-1:0]   lvl [NUM_SRC],
  output cand_t              best
);
  localparam int DEPTH  = $clog2(NUM_SRC);
  localparam int LEAVES = 1 << DEPTH;

  for (genvar s = 0; s <= DEPTH; s++) begin : g_stg
    localparam int W = LEAVES >> s;
    cand_t c [W];
    if (s == 0) begin : g_leaf
      for (genvar i = 0; i < W; i++) begin : g_in
        if (i < NUM_SRC) begin : g_real
          assign c[i] = '{vld: req[i] && (lvl[i] != LVL_OFF),
                          lvl: lvl[i], idx: IDX_W'(i)};
        end else begin : g_pad
          assign c[i] = '0;
        end
      end
    end else begin : g_red
      for (genvar j = 0; j < W; j++) begin : g_node
        assign c[j] = pick_cand(g_stg[s-1].c[2*j], g_stg[s-1].c[2*j+1]);
      end
    end
  end

  assign best = g_stg[DEPTH].c[0];
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_lvl_pkg::*;
#(
  parameter int VEC_BASE  = 16,
  parameter int NMI_LEVEL = 15,
  parameter int NMI_VEC   = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  cand_t            best,
  input  logic             nmi_req,
  input  logic [LVL_W-1:0] cpu_mask,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_level,
  output logic [IDX_W-1:0] irq_vec
);
  logic             nx_req;
  logic [LVL_W-1:0] nx_lvl;
  logic [IDX_W-1:0] nx_vec;

  always_comb begin
    nx_req = 1'b0;
    nx_lvl = LVL_OFF;
    nx_vec = '0;
    if (nmi_req) begin
      nx_req = 1'b1;
      nx_lvl = LVL_W'(NMI_LEVEL);
      nx_vec = IDX_W'(NMI_VEC);
    end else if (best.vld && best.lvl < cpu_mask) begin
      nx_req = 1'b1;
      nx_lvl = best.lvl;
      nx_vec = IDX_W'(VEC_BASE) + best.idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_level <= LVL_OFF;
      irq_vec   <= '0;
    end else begin
      irq_req   <= nx_req;
      irq_level <= nx_lvl;
      irq_vec   <= nx_vec;
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_lvl_pkg::*;
#(
  parameter int NUM_SRC   = 48,
  parameter int VEC_BASE  = 16,
  parameter int NMI_LEVEL = 15,
  parameter int NMI_VEC   = 15,
  localparam int ADDR_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               nmi_req,
  input  logic [LVL_W-1:0]   cpu_mask,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [LVL_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [LVL_W-1:0]   rd_data,
  output logic               irq_req,
  output logic [LVL_W-1:0]   irq_level,
  output logic [IDX_W-1:0]   irq_vec
);
  logic [LVL_W-1:0] lvl [NUM_SRC];
  cand_t            best;

  irq_lvl_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lvl_o(lvl)
  );

  irq_prio_tree #(.NUM_SRC(NUM_SRC)) u_tree (
    .req(src_req), .lvl(lvl), .best(best)
  );

  irq_out_stage #(.VEC_BASE(VEC_BASE), .NMI_LEVEL(NMI_LEVEL), .NMI_VEC(NMI_VEC)) u_out (
    .clk(clk), .rst(rst), .best(best), .nmi_req(nmi_req), .cpu_mask(cpu_mask),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec)
  );
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import irq_lvl_pkg::*;
#(
  parameter int NUM_SRC   = 48,
  parameter int NMI_LEVEL = 15,
  parameter int NMI_VEC   = 15
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_req,
  input logic               nmi_req,
  input logic [LVL_W-1:0]   cpu_mask,
  input logic               irq_req,
  input logic [LVL_W-1:0]   irq_level,
  input logic [IDX_W-1:0]   irq_vec
);
  AST_NMI_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
    nmi_req |=> (irq_req && irq_level == LVL_W'(NMI_LEVEL) && irq_vec == IDX_W'(NMI_VEC))); // R8

  AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !$past(nmi_req)) |-> (irq_level < $past(cpu_mask))); // R6

  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_level == LVL_OFF && irq_vec == '0)); // R7

  AST_NO_SOURCE_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    (src_req == '0 && !nmi_req) |=> !irq_req); // R10

  AST_PARKED_NEVER_SENT: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_level != LVL_OFF)); // R3
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NMI_LEVEL(NMI_LEVEL), .NMI_VEC(NMI_VEC)
) u_chk (
  .clk(clk), .rst(rst), .src_req(src_req), .nmi_req(nmi_req), .cpu_mask(cpu_mask),
  .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec)
);

// File: tb/irq_level_ctrl_bench.sv
`timescale 1ns/1ps
module irq_level_ctrl_bench;
  localparam int N = 48;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] src_req = '0;
  logic         nmi_req = 1'b0;
  logic [4:0]   cpu_mask = 5'd31;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_addr = '0;
  logic [4:0]   wr_data = '0;
  logic [5:0]   rd_addr = '0;
  logic [4:0]   rd_data;
  logic         irq_req;
  logic [4:0]   irq_level;
  logic [5:0]   irq_vec;

  int tests = 0;
  int fails = 0;
  logic [4:0] m_lvl [N];
  logic [31:0] lfsr = 32'hACE1_2345;

  always #2 clk = ~clk;

  irq_level_ctrl u_irq_level_ctrl (
    .clk(clk), .rst(rst), .src_req(src_req), .nmi_req(nmi_req), .cpu_mask(cpu_mask),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_lvl(input int a, input int v);
    wr_en = 1'b1; wr_addr = 6'(a); wr_data = 5'(v);
    tick();
    wr_en = 1'b0;
    if (a < N) m_lvl[a] = 5'(v);
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    rd_addr = 6'(a);
    tick();
    chk(rd_data == 5'(exp), tag, rd_data, exp);
  endtask

  // Reference model built from the requirements: smallest level, lowest index.
  task automatic model(output bit r, output int l, output int v);
    int bi;
    int bl;
    bi = -1; bl = 31;
    for (int i = 0; i < N; i++)
      if (src_req[i] && m_lvl[i] != 5'd31 && int'(m_lvl[i]) < bl) begin
        bl = m_lvl[i]; bi = i;
      end
    if (nmi_req) begin r = 1; l = 15; v = 15; end
    else if (bi >= 0 && bl < int'(cpu_mask)) begin r = 1; l = bl; v = 16 + bi; end
    else begin r = 0; l = 31; v = 0; end
  endtask

  task automatic out_chk(input string tag);
    bit r; int l; int v;
    model(r, l, v);
    chk(irq_req == r, {tag, " req"}, irq_req, r);
    chk(irq_level == 5'(l), {tag, " level"}, irq_level, l);
    chk(irq_vec == 6'(v), {tag, " vec"}, irq_vec, v);
  endtask

  task automatic apply(input logic [N-1:0] rq, input int msk, input bit nm);
    src_req = rq; cpu_mask = 5'(msk); nmi_req = nm;
    tick();
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) rd_chk(i, 31, "R1 reset level");
    chk(irq_req == 1'b0, "R1 reset req", irq_req, 0);
    chk(irq_level == 5'd31, "R1 reset level out", irq_level, 31);
    chk(irq_vec == 6'd0, "R1 reset vec", irq_vec, 0);
  endtask

  task automatic t_regbus();
    wr_lvl(0, 3); wr_lvl(47, 9); wr_lvl(21, 0);
    rd_chk(0, 3, "R2 readback 0");
    rd_chk(47, 9, "R2 readback 47");
    rd_chk(21, 0, "R2 readback 21");
    wr_lvl(50, 1); wr_lvl(63, 2);
    rd_chk(50, 0, "R11 read unmapped");
    rd_chk(63, 0, "R11 read unmapped 63");
    for (int i = 0; i < N; i++) rd_chk(i, int'(m_lvl[i]), "R11 no stray write");
  endtask

  task automatic t_disabled();
    wr_lvl(5, 31);
    apply(N'(1) << 5, 31, 0);
    out_chk("R3 parked line");
    chk(irq_req == 1'b0, "R3 parked no req", irq_req, 0);
    apply('0, 31, 0);
    out_chk("R7 idle");
  endtask

  task automatic t_priority();
    wr_lvl(3, 10); wr_lvl(40, 4);
    apply((N'(1) << 3) | (N'(1) << 40), 31, 0);
    chk(irq_vec == 6'd56 && irq_level == 5'd4, "R4 lower level wins", irq_vec, 56);
    out_chk("R9 vector");
  endtask

  task automatic t_tie();
    wr_lvl(7, 6); wr_lvl(20, 6);
    apply((N'(1) << 7) | (N'(1) << 20), 31, 0);
    chk(irq_vec == 6'd23, "R5 tie lower index", irq_vec, 23);
    out_chk("R5 tie");
  endtask

  task automatic t_mask();
    apply(N'(1) << 7, 6, 0);
    chk(irq_req == 1'b0, "R6 level equals mask", irq_req, 0);
    out_chk("R6 equal");
    apply(N'(1) << 7, 7, 0);
    chk(irq_req == 1'b1, "R6 level below mask", irq_req, 1);
    out_chk("R6 below");
    apply(N'(1) << 7, 0, 0);
    out_chk("R6 mask zero");
  endtask

  task automatic t_nmi();
    apply((N'(1) << 21) | (N'(1) << 7), 0, 1);
    chk(irq_vec == 6'd15 && irq_level == 5'd15 && irq_req, "R8 nmi override", irq_vec, 15);
    apply('1, 31, 1);
    out_chk("R8 nmi all");
    apply('0, 31, 0);
  endtask

  task automatic t_timing();
    wr_lvl(2, 3);
    apply('0, 31, 0);
    src_req = N'(1) << 2;
    #1;
    chk(irq_req == 1'b0, "R10 not before edge", irq_req, 0);
    @(posedge clk); @(negedge clk);
    chk(irq_req == 1'b1 && irq_vec == 6'd18, "R10 after one edge", irq_vec, 18);
    apply('0, 31, 0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 200; k++) begin
      logic [N-1:0] a;
      logic [N-1:0] b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] < 4'd5) wr_lvl(int'(lfsr[13:8]) % N, int'(lfsr[20:16]));
      a = {lfsr[15:0], lfsr, lfsr[7:0]} ^ N'(k * 7919);
      b = {lfsr[7:0], lfsr[31:0] ^ 32'h5A5A_3C3C, lfsr[23:16]};
      apply(a & b, int'(lfsr[28:24]), lfsr[30:27] == 4'hF);
      out_chk("R4 R5 R6 random");
    end
    apply('0, 31, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_lvl[i] = 5'd31;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regbus();
    t_disabled();
    t_priority();
    t_tie();
    t_mask();
    t_nmi();
    t_timing();
    t_random();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule